// File: doc/BRIEF.md
# PFC Protection and Mode Supervisor

This block decides, cycle by cycle, whether a power-factor-correction boost stage may switch. It takes digitized comparator flags: supply good, input-sense turn-on and turn-off thresholds, open loop, two over-voltage levels with their release flags, standby request, low line, light load, and the bulk-voltage high and low thresholds. From these flags it drives the gate permission, a soft-start request pulse, a latched-fault indication, a bulk-OK signal and the enable for the boost-follower current source. Every flag passes through a two-stage synchronizer before any logic reads it. All outputs are registered.

A mode state machine steps through power-off, waiting for input, running, standby and latched fault. An over-voltage controller tracks the first trip, which does not latch, and the second trip. The second trip either latches or restarts through soft-start. A strap input selects which, and the block captures that strap once on each rising edge of supply good. When both over-voltage trips fire together, the block holds the gate off until both release flags are present, then resumes switching without a soft-start and without latching.

Top module: `pfc_supervisor`

## Requirements
- R1: After reset, gate_enable, softstart_req, fault_latched, vb_ok and bofo_en are all 0.
- R2: Once supply_ok is high and bop_on_flag is high, the block enters run, issues exactly one softstart_req pulse and raises gate_enable.
- R3: Brownout has hysteresis. In run, bop_off_flag high turns the gate off. Return to run requires bop_on_flag. While both flags are low, the present state holds. Each return to run issues one soft-start pulse.
- R4: While olp_flag is high, gate_enable is 0. When olp_flag falls, switching resumes without a soft-start pulse.
- R5: ovp1_trip turns the gate off. The gate stays off after the trip flag falls, until ovp1_release is seen. Switching then resumes without a soft-start pulse.
- R6: With the strap captured as 0 (auto restart), ovp2_trip turns the gate off. The later ovp2_release resumes switching with one soft-start pulse and leaves fault_latched at 0.
- R7: With the strap captured as 1 (latch mode), a lone ovp2_trip sets fault_latched and holds the gate off. Release flags have no effect on this state. Only supply_ok going low clears it.
- R8: ovp2_mode_strap is captured only when supply_ok rises. Later changes to the strap do not change the recovery mode.
- R9: If ovp2_trip rises while the first over-voltage trip is active or rising, the gate stays off until ovp1_release and ovp2_release are both high. Switching then resumes with no soft-start pulse and no latched fault, in either strap mode.
- R10: While standby_req is high, gate_enable, vb_ok and bofo_en are 0. After release, the block returns to run through one soft-start pulse.
- R11: In run, vb_ok rises when vb_high_flag is high and falls when vb_low_flag is high. Between those events it holds its value.
- R12: bofo_en is 1 only in run, and only when low_line_flag and light_load_flag are both high.
- R13: softstart_req is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply above undervoltage lockout |
| ovp2_mode_strap | input | 1 | 1 selects latch mode, 0 selects auto restart, for the second over-voltage trip |
| bop_on_flag | input | 1 | Input sense above the turn-on level |
| bop_off_flag | input | 1 | Input sense below the turn-off level |
| olp_flag | input | 1 | Output sense below the open-loop level |
| ovp1_trip | input | 1 | Bulk above the first over-voltage level |
| ovp1_release | input | 1 | Bulk back below rated |
| ovp2_trip | input | 1 | Second over-voltage sense above its level |
| ovp2_release | input | 1 | Second over-voltage sense out of its hysteresis |
| standby_req | input | 1 | Standby request |
| low_line_flag | input | 1 | Low-line condition |
| light_load_flag | input | 1 | Light-load condition |
| vb_high_flag | input | 1 | Bulk above 95 % of rated |
| vb_low_flag | input | 1 | Bulk below the adjustable low threshold |
| gate_enable | output | 1 | Permission for the gate to switch |
| softstart_req | output | 1 | One-cycle soft-start request |
| fault_latched | output | 1 | Latched second over-voltage fault |
| vb_ok | output | 1 | Bulk voltage good |
| bofo_en | output | 1 | Boost-follower current enable |

## Verification
The bench sweeps all four combinations of low line and light load, both in run and in standby. Comparing the two sweeps shows whether the AND condition and the run qualification are each present. It applies each gate inhibitor (open loop, first trip, second trip, standby, brownout) alone, then releases it, and counts soft-start pulses. The counts separate the recoveries that must restart from those that must simply resume. It runs the second over-voltage trip in both strap modes, with the strap toggled after capture. It also runs a joint trip with only one release flag present, which separates the joint rule from the single-trip rules.

// File: rtl/pfc_sup_pkg.sv
`timescale 1ns/1ps
package pfc_sup_pkg;
  typedef enum logic [2:0] {
    ST_OFF, ST_WAIT_IN, ST_RUN, ST_STANDBY, ST_LATCHED
  } sup_state_e;

  localparam int NFLAGS      = 14;
  localparam int F_SUP       = 0;
  localparam int F_STRAP     = 1;
  localparam int F_BOP_ON    = 2;
  localparam int F_BOP_OFF   = 3;
  localparam int F_OLP       = 4;
  localparam int F_OVP1_TRIP = 5;
  localparam int F_OVP1_REL  = 6;
  localparam int F_OVP2_TRIP = 7;
  localparam int F_OVP2_REL  = 8;
  localparam int F_STBY      = 9;
  localparam int F_LOWLINE   = 10;
  localparam int F_LIGHT     = 11;
  localparam int F_VB_HI     = 12;
  localparam int F_VB_LO     = 13;
endpackage

// File: rtl/pfc_flag_sync.sv
`timescale 1ns/1ps
module pfc_flag_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pfc_ovp_ctrl.sv
`timescale 1ns/1ps
module pfc_ovp_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic latch_mode,
  input  logic ovp1_trip,
  input  logic ovp1_rel,
  input  logic ovp2_trip,
  input  logic ovp2_rel,
  output logic ovp_block,
  output logic latch_evt,
  output logic restart_evt
);
  logic o1_q, o2_q, joint_q;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      o1_q        <= 1'b0;
      o2_q        <= 1'b0;
      joint_q     <= 1'b0;
      latch_evt   <= 1'b0;
      restart_evt <= 1'b0;
    end else begin
      latch_evt   <= 1'b0;
      restart_evt <= 1'b0;
      if (ovp1_trip) o1_q <= 1'b1;
      else if (o1_q && !joint_q && ovp1_rel) o1_q <= 1'b0;

      if (ovp2_trip && !o2_q) begin
        o2_q <= 1'b1;
        if (o1_q || ovp1_trip) joint_q <= 1'b1;
        else if (latch_mode) latch_evt <= 1'b1;
      end else if (o2_q && !joint_q && ovp2_rel && !ovp2_trip) begin
        o2_q <= 1'b0;
        if (!latch_mode) restart_evt <= 1'b1;
      end

      if (joint_q && ovp1_rel && ovp2_rel && !ovp1_trip && !ovp2_trip) begin
        joint_q <= 1'b0;
        o1_q    <= 1'b0;
        o2_q    <= 1'b0;
      end
    end
  end

  assign ovp_block = o1_q | o2_q | joint_q;
endmodule

// File: rtl/pfc_mode_fsm.sv
`timescale 1ns/1ps
module pfc_mode_fsm
  import pfc_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sup,
  input  logic       bop_on,
  input  logic       bop_off,
  input  logic       stby,
  input  logic       latch_evt,
  output sup_state_e state,
  output logic       enter_run
);
  sup_state_e st_q, st_d;

  always_comb begin
    st_d      = st_q;
    enter_run = 1'b0;
    if (!sup) begin
      st_d = ST_OFF;
    end else begin
      case (st_q)
        ST_OFF:     st_d = ST_WAIT_IN;
        ST_WAIT_IN: begin
          if (stby) st_d = ST_STANDBY;
          else if (bop_on && !bop_off) begin
            st_d      = ST_RUN;
            enter_run = 1'b1;
          end
        end
        ST_RUN: begin
          if (latch_evt)    st_d = ST_LATCHED;
          else if (stby)    st_d = ST_STANDBY;
          else if (bop_off) st_d = ST_WAIT_IN;
        end
        ST_STANDBY: if (!stby) st_d = ST_WAIT_IN;
        ST_LATCHED: st_d = ST_LATCHED;
        default:    st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_OFF;
    else     st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/pfc_supervisor.sv
`timescale 1ns/1ps
module pfc_supervisor
  import pfc_sup_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic ovp2_mode_strap,
  input  logic bop_on_flag,
  input  logic bop_off_flag,
  input  logic olp_flag,
  input  logic ovp1_trip,
  input  logic ovp1_release,
  input  logic ovp2_trip,
  input  logic ovp2_release,
  input  logic standby_req,
  input  logic low_line_flag,
  input  logic light_load_flag,
  input  logic vb_high_flag,
  input  logic vb_low_flag,
  output logic gate_enable,
  output logic softstart_req,
  output logic fault_latched,
  output logic vb_ok,
  output logic bofo_en
);
  logic [NFLAGS-1:0] raw_flags, flg_s;

  always_comb begin
    raw_flags              = '0;
    raw_flags[F_SUP]       = supply_ok;
    raw_flags[F_STRAP]     = ovp2_mode_strap;
    raw_flags[F_BOP_ON]    = bop_on_flag;
    raw_flags[F_BOP_OFF]   = bop_off_flag;
    raw_flags[F_OLP]       = olp_flag;
    raw_flags[F_OVP1_TRIP] = ovp1_trip;
    raw_flags[F_OVP1_REL]  = ovp1_release;
    raw_flags[F_OVP2_TRIP] = ovp2_trip;
    raw_flags[F_OVP2_REL]  = ovp2_release;
    raw_flags[F_STBY]      = standby_req;
    raw_flags[F_LOWLINE]   = low_line_flag;
    raw_flags[F_LIGHT]     = light_load_flag;
    raw_flags[F_VB_HI]     = vb_high_flag;
    raw_flags[F_VB_LO]     = vb_low_flag;
  end

  pfc_flag_sync #(.W(NFLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .din (raw_flags), .dout (flg_s)
  );

  logic sup_s, strap_s, olp_s, ovp1_s, ovp2_s, stby_s, low_s, light_s, vb_lo_s;
  assign sup_s   = flg_s[F_SUP];
  assign strap_s = flg_s[F_STRAP];
  assign olp_s   = flg_s[F_OLP];
  assign ovp1_s  = flg_s[F_OVP1_TRIP];
  assign ovp2_s  = flg_s[F_OVP2_TRIP];
  assign stby_s  = flg_s[F_STBY];
  assign low_s   = flg_s[F_LOWLINE];
  assign light_s = flg_s[F_LIGHT];
  assign vb_lo_s = flg_s[F_VB_LO];

  // Strap capture on the synchronized supply rising edge only
  logic sup_prev_q, latch_mode_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      sup_prev_q   <= 1'b0;
      latch_mode_q <= 1'b0;
    end else begin
      sup_prev_q <= sup_s;
      if (sup_s && !sup_prev_q) latch_mode_q <= strap_s;
    end
  end

  sup_state_e state;
  logic enter_run, ovp_block, latch_evt, restart_evt, in_run;

  pfc_mode_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .sup       (sup_s),
    .bop_on    (flg_s[F_BOP_ON]),
    .bop_off   (flg_s[F_BOP_OFF]),
    .stby      (stby_s),
    .latch_evt (latch_evt),
    .state     (state),
    .enter_run (enter_run)
  );

  assign in_run = (state == ST_RUN);

  pfc_ovp_ctrl u_ovp (
    .clk         (clk),
    .rst         (rst),
    .enable      (in_run),
    .latch_mode  (latch_mode_q),
    .ovp1_trip   (ovp1_s),
    .ovp1_rel    (flg_s[F_OVP1_REL]),
    .ovp2_trip   (ovp2_s),
    .ovp2_rel    (flg_s[F_OVP2_REL]),
    .ovp_block   (ovp_block),
    .latch_evt   (latch_evt),
    .restart_evt (restart_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_enable   <= 1'b0;
      softstart_req <= 1'b0;
      fault_latched <= 1'b0;
      vb_ok         <= 1'b0;
      bofo_en       <= 1'b0;
    end else begin
      gate_enable   <= in_run && sup_s && !ovp_block && !ovp1_s && !ovp2_s
                       && !olp_s && !stby_s && !flg_s[F_BOP_OFF];
      softstart_req <= enter_run || restart_evt;
      fault_latched <= (state == ST_LATCHED);
      bofo_en       <= in_run && !stby_s && low_s && light_s;
      if (!in_run || stby_s || vb_lo_s) vb_ok <= 1'b0;
      else if (flg_s[F_VB_HI])          vb_ok <= 1'b1;
    end
  end
endmodule

// File: rtl/pfc_supervisor_chk.sv
`timescale 1ns/1ps
module pfc_supervisor_chk (
  input logic clk,
  input logic rst,
  input logic gate_enable,
  input logic softstart_req,
  input logic fault_latched,
  input logic vb_ok,
  input logic bofo_en,
  input logic ovp1_s,
  input logic ovp2_s,
  input logic olp_s,
  input logic stby_s,
  input logic low_s,
  input logic light_s,
  input logic vb_lo_s
);
  AST_OLP_GATE_OFF:   assert property (@(posedge clk) disable iff (rst) olp_s |=> !gate_enable); // R4
  AST_OVP1_GATE_OFF:  assert property (@(posedge clk) disable iff (rst) ovp1_s |=> !gate_enable); // R5
  AST_OVP2_GATE_OFF:  assert property (@(posedge clk) disable iff (rst) ovp2_s |=> !gate_enable); // R6
  AST_FAULT_NO_GATE:  assert property (@(posedge clk) disable iff (rst) fault_latched |-> !gate_enable); // R7
  AST_STBY_QUIET:     assert property (@(posedge clk) disable iff (rst) stby_s |=> (!gate_enable && !bofo_en && !vb_ok)); // R10
  AST_VB_LOW_DROPS:   assert property (@(posedge clk) disable iff (rst) vb_lo_s |=> !vb_ok); // R11
  AST_BOFO_BOTH:      assert property (@(posedge clk) disable iff (rst) bofo_en |-> $past(low_s && light_s)); // R12
  AST_SS_ONE_CYCLE:   assert property (@(posedge clk) disable iff (rst) softstart_req |=> !softstart_req); // R13
endmodule

bind pfc_supervisor pfc_supervisor_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .gate_enable   (gate_enable),
  .softstart_req (softstart_req),
  .fault_latched (fault_latched),
  .vb_ok         (vb_ok),
  .bofo_en       (bofo_en),
  .ovp1_s        (ovp1_s),
  .ovp2_s        (ovp2_s),
  .olp_s         (olp_s),
  .stby_s        (stby_s),
  .low_s         (low_s),
  .light_s       (light_s),
  .vb_lo_s       (vb_lo_s)
);

// File: tb/tb_pfc_supervisor.sv
`timescale 1ns/1ps
module tb_pfc_supervisor;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 0, strap = 0, bop_on = 0, bop_off = 0, olp = 0;
  logic o1t = 0, o1r = 0, o2t = 0, o2r = 0, stby = 0, low = 0, light = 0;
  logic vbh = 0, vbl = 0;
  logic gate_enable, softstart_req, fault_latched, vb_ok, bofo_en;

  int checks = 0, failures = 0, ss_cnt = 0, ss_wide = 0, exp_ss = 0;
  logic ss_prev = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pfc_supervisor dut (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .ovp2_mode_strap(strap),
    .bop_on_flag(bop_on), .bop_off_flag(bop_off), .olp_flag(olp),
    .ovp1_trip(o1t), .ovp1_release(o1r), .ovp2_trip(o2t), .ovp2_release(o2r),
    .standby_req(stby), .low_line_flag(low), .light_load_flag(light),
    .vb_high_flag(vbh), .vb_low_flag(vbl),
    .gate_enable(gate_enable), .softstart_req(softstart_req),
    .fault_latched(fault_latched), .vb_ok(vb_ok), .bofo_en(bofo_en)
  );

  always @(negedge clk) begin
    if (!rst && softstart_req) ss_cnt++;
    if (!rst && softstart_req && ss_prev) ss_wide++;
    ss_prev = softstart_req;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    settle();
    // R1 reset state
    check("R1 gate", gate_enable, 0);
    check("R1 softstart", softstart_req, 0);
    check("R1 fault", fault_latched, 0);
    check("R1 vb_ok", vb_ok, 0);
    check("R1 bofo", bofo_en, 0);

    // R2 power-up with strap = 0 (auto restart)
    strap = 0; supply_ok = 1; bop_on = 1;
    settle(); exp_ss++;
    check("R2 gate on", gate_enable, 1);
    check("R2 one softstart", ss_cnt, exp_ss);
    bop_on = 0; settle();
    check("R3 in-band hold", gate_enable, 1);

    // R11 bulk-OK hysteresis
    check("R11 vb_ok initial", vb_ok, 0);
    vbh = 1; settle(); check("R11 vb_ok set", vb_ok, 1);
    vbh = 0; settle(); check("R11 vb_ok hold high", vb_ok, 1);
    vbl = 1; settle(); check("R11 vb_ok cleared", vb_ok, 0);
    vbl = 0; settle(); check("R11 vb_ok hold low", vb_ok, 0);

    // R12 sweep in run
    for (int i = 0; i < 4; i++) begin
      low = i[0]; light = i[1]; settle();
      check("R12 bofo in run", bofo_en, (i == 3) ? 1 : 0);
    end
    low = 0; light = 0; settle();

    // R4 open loop
    olp = 1; settle(); check("R4 olp gate off", gate_enable, 0);
    olp = 0; settle(); check("R4 olp resume", gate_enable, 1);
    check("R4 no softstart", ss_cnt, exp_ss);

    // R5 first over-voltage
    o1t = 1; settle(); check("R5 trip gate off", gate_enable, 0);
    o1t = 0; settle(); check("R5 held until release", gate_enable, 0);
    o1r = 1; settle(); check("R5 resume", gate_enable, 1);
    check("R5 no softstart", ss_cnt, exp_ss);
    o1r = 0; settle();

    // R6/R8 second over-voltage, auto mode; strap change ignored
    strap = 1; settle();
    o2t = 1; settle();
    check("R6 trip gate off", gate_enable, 0);
    check("R8 strap ignored no latch", fault_latched, 0);
    o2t = 0; o2r = 1; settle(); exp_ss++;
    check("R6 resume", gate_enable, 1);
    check("R6 softstart", ss_cnt, exp_ss);
    check("R6 no fault", fault_latched, 0);
    o2r = 0; settle();

    // R9 joint trip in auto mode
    o1t = 1; o2t = 1; settle();
    check("R9 joint gate off", gate_enable, 0);
    o1t = 0; o2t = 0; o1r = 1; settle();
    check("R9 one release insufficient", gate_enable, 0);
    o2r = 1; settle();
    check("R9 joint resume", gate_enable, 1);
    check("R9 no softstart", ss_cnt, exp_ss);
    o1r = 0; o2r = 0; settle();

    // R10 standby with bofo sweep
    stby = 1; vbh = 1; settle();
    for (int i = 0; i < 4; i++) begin
      low = i[0]; light = i[1]; settle();
      check("R10/R12 bofo in standby", bofo_en, 0);
    end
    check("R10 gate off", gate_enable, 0);
    check("R10 vb_ok off", vb_ok, 0);
    bop_on = 1; stby = 0; settle(); exp_ss++;
    check("R10 gate back", gate_enable, 1);
    check("R10 softstart", ss_cnt, exp_ss);
    check("R10 bofo back", bofo_en, 1);
    low = 0; light = 0; vbh = 0;

    // R3 brownout hysteresis
    bop_on = 0; bop_off = 1; settle();
    check("R3 brownout gate off", gate_enable, 0);
    bop_off = 0; settle();
    check("R3 in-band stays off", gate_enable, 0);
    bop_on = 1; settle(); exp_ss++;
    check("R3 recovered", gate_enable, 1);
    check("R3 softstart", ss_cnt, exp_ss);

    // R7 latch mode: strap 1 captured at new supply rise
    supply_ok = 0; settle();
    check("R7 off with supply low", gate_enable, 0);
    supply_ok = 1; settle(); exp_ss++;
    check("R8 restart gate", gate_enable, 1);
    strap = 0; settle();
    o2t = 1; settle();
    check("R7 fault latched", fault_latched, 1);
    check("R7 gate off", gate_enable, 0);
    o2t = 0; o2r = 1; o1r = 1; settle();
    check("R7 release ignored", fault_latched, 1);
    check("R7 gate stays off", gate_enable, 0);
    o2r = 0; o1r = 0;
    supply_ok = 0; settle();
    check("R7 cleared by supply", fault_latched, 0);

    // R9 joint trip in latch mode
    strap = 1; supply_ok = 1; settle(); exp_ss++;
    o1t = 1; o2t = 1; settle();
    check("R9 latch mode no fault", fault_latched, 0);
    check("R9 latch mode gate off", gate_enable, 0);
    o1t = 0; o2t = 0; o1r = 1; o2r = 1; settle();
    check("R9 latch mode resume", gate_enable, 1);
    check("R9 latch mode softstart count", ss_cnt, exp_ss);
    check("R13 pulse width", ss_wide, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule